// File: doc/BRIEF.md
# Sorted Linked-List Manager

This engine keeps a singly linked list of records in an external word memory, always ordered by ascending key. Software or another block writes a record into memory, then hands its address to the engine with an insert command, and the engine splices it in at the right place. A delete command carries a key value. The engine unlinks the first record that holds that key, or reports that no such record exists. The engine owns the list head pointer. All walking is done by reading and writing the link words of the records.

Each record uses five 32-bit words. The key is at byte offset 0 and the link is at byte offset 4. The remaining three words carry payload, which the engine never touches. A pointer value of zero means "no record", both for the head and for a link. The memory port is byte-addressed with word-aligned accesses. A read returns the word at the address presented in the previous cycle, so the read latency is one cycle. Only one command runs at a time.

Top module: `sll_list_mgr`

## Requirements
- R1: After reset, busy_o, done_o, notfound_o and mem_we_o are low and the list is empty, so a delete completes with notfound_o high.
- R2: An insert into an empty list makes the new record the head and writes 0 into its link word.
- R3: If the head key is greater than the new key, the new record's link is written with the old head and the new record becomes the head. Keys compare as unsigned 32-bit values.
- R4: Otherwise the new record is placed just before the first following record whose key is greater than the new key: new.link = that record and the predecessor's link = new. Records with equal keys therefore keep their insertion order.
- R5: If no greater key exists, the new record becomes the tail: its link is written 0 and the previous tail's link points to it.
- R6: A delete whose ID equals the head key replaces the head with the head record's link.
- R7: A delete that matches a later record writes that record's link into its predecessor's link. Only the first matching record is removed.
- R8: A delete with no matching key, including on an empty list, leaves every memory word unchanged and completes with notfound_o high. notfound_o stays low while a command runs and holds its value until the next command starts.
- R9: A command starts when start_i is high while the engine is idle. cmd_i value 0 selects insert (arg_i is the record byte address) and 1 selects delete (arg_i is the ID). busy_o is high while the command runs. done_o pulses for exactly one cycle, with busy_o low, when the command finishes. start_i is ignored while busy_o is high.
- R10: The engine writes only the link word (record address + 4). Key words and the three payload words (offsets 8, 12 and 16) are never written, and mem_we_o is high only while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command strobe, sampled while idle |
| cmd_i | input | 1 | 0 = insert, 1 = delete |
| arg_i | input | DATA_W | Record address (insert) or key ID (delete) |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| notfound_o | output | 1 | Last delete found no matching key |
| mem_addr_o | output | ADDR_W | Memory byte address (word-aligned) |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Read data for the address of the previous cycle |

## Verification
Four keys are inserted in every one of their 24 arrival orders, so each insert lands in the empty, new-head, interior or tail case in every combination. After each command the whole chain of link words is compared against a sorted list kept in the bench. The same orders drive deletions that hit the head, interior and tail, and a missing key is deleted on full and empty lists to show that memory stays untouched. Separate runs use equal keys to show the stable tie order, a key with the top bit set to show unsigned comparison, and a second start pulse during a busy insert to show that it is ignored.

// File: rtl/sll_pkg.sv
package sll_pkg;

  typedef enum logic {
    CMD_INSERT = 1'b0,
    CMD_DELETE = 1'b1
  } sll_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RWAIT,
    ST_NEWKEY,
    ST_HEADKEY,
    ST_HEADLINK,
    ST_CURLINK,
    ST_NXTKEY,
    ST_NXTLINK,
    ST_WFIRST,
    ST_WLAST
  } sll_state_e;

endpackage

// File: rtl/sll_key_cmp.sv
module sll_key_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o,
  output logic         eq_o,
  output logic         a_zero_o
);
  // unsigned magnitude compare of a read word against the reference key
  always_comb begin
    gt_o     = (a_i > b_i);
    eq_o     = (a_i == b_i);
    a_zero_o = (a_i == '0);
  end
endmodule

// File: rtl/sll_mem_req.sv
module sll_mem_req #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_n_i,
  input  logic [DATA_W-1:0] wdata_n_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  // output register stage: the memory sees a clean registered request
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o    <= we_n_i;
      mem_addr_o  <= addr_n_i;
      mem_wdata_o <= wdata_n_i;
    end
  end
endmodule

// File: rtl/sll_ctrl.sv
module sll_ctrl
  import sll_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              cmd_i,
  input  logic [DATA_W-1:0] arg_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              req_we_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              notfound_o
);
  localparam int              LINK_BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] LINK_OFS = ADDR_W'(LINK_BYTES);

  sll_state_e        st_q, st_n, ret_q, ret_n;
  sll_cmd_e          op_q, op_n;
  logic [ADDR_W-1:0] head_q, head_n;
  logic [ADDR_W-1:0] cur_q, cur_n;
  logic [ADDR_W-1:0] nxt_q, nxt_n;
  logic [ADDR_W-1:0] newp_q, newp_n;
  logic [DATA_W-1:0] key_q, key_n;
  logic              fin, fin_nf, accept;
  logic              rd_gt, rd_eq, rd_zero;
  logic [ADDR_W-1:0] rd_ptr;

  assign rd_ptr = mem_rdata_i[ADDR_W-1:0];
  assign accept = (st_q == ST_IDLE) && start_i;

  // one comparator serves both commands: key_q holds new key or the ID
  sll_key_cmp #(.W(DATA_W)) u_cmp (
    .a_i      (mem_rdata_i),
    .b_i      (key_q),
    .gt_o     (rd_gt),
    .eq_o     (rd_eq),
    .a_zero_o (rd_zero)
  );

  function automatic logic [ADDR_W-1:0] link_of(input logic [ADDR_W-1:0] p);
    return p + LINK_OFS;
  endfunction

  always_comb begin
    st_n        = st_q;
    ret_n       = ret_q;
    op_n        = op_q;
    head_n      = head_q;
    cur_n       = cur_q;
    nxt_n       = nxt_q;
    newp_n      = newp_q;
    key_n       = key_q;
    req_we_o    = 1'b0;
    req_addr_o  = '0;
    req_wdata_o = '0;
    fin         = 1'b0;
    fin_nf      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          op_n = sll_cmd_e'(cmd_i);
          if (sll_cmd_e'(cmd_i) == CMD_INSERT) begin
            newp_n     = arg_i[ADDR_W-1:0];
            req_addr_o = arg_i[ADDR_W-1:0];
            ret_n      = ST_NEWKEY;
            st_n       = ST_RWAIT;
          end else begin
            key_n = arg_i;
            if (head_q == '0) begin
              fin    = 1'b1;
              fin_nf = 1'b1;
            end else begin
              req_addr_o = head_q;
              ret_n      = ST_HEADKEY;
              st_n       = ST_RWAIT;
            end
          end
        end
      end
      ST_RWAIT: st_n = ret_q;
      ST_NEWKEY: begin
        key_n = mem_rdata_i;
        if (head_q == '0) begin
          req_we_o    = 1'b1;
          req_addr_o  = link_of(newp_q);
          req_wdata_o = '0;
          head_n      = newp_q;
          st_n        = ST_WLAST;
        end else begin
          req_addr_o = head_q;
          ret_n      = ST_HEADKEY;
          st_n       = ST_RWAIT;
        end
      end
      ST_HEADKEY: begin
        if (op_q == CMD_INSERT && rd_gt) begin
          req_we_o    = 1'b1;
          req_addr_o  = link_of(newp_q);
          req_wdata_o = DATA_W'(head_q);
          head_n      = newp_q;
          st_n        = ST_WLAST;
        end else if (op_q == CMD_DELETE && rd_eq) begin
          req_addr_o = link_of(head_q);
          ret_n      = ST_HEADLINK;
          st_n       = ST_RWAIT;
        end else begin
          cur_n      = head_q;
          req_addr_o = link_of(head_q);
          ret_n      = ST_CURLINK;
          st_n       = ST_RWAIT;
        end
      end
      ST_HEADLINK: begin
        head_n = rd_ptr;
        fin    = 1'b1;
        st_n   = ST_IDLE;
      end
      ST_CURLINK: begin
        nxt_n = rd_ptr;
        if (rd_zero) begin
          if (op_q == CMD_INSERT) begin
            req_we_o    = 1'b1;
            req_addr_o  = link_of(newp_q);
            req_wdata_o = '0;
            st_n        = ST_WFIRST;
          end else begin
            fin    = 1'b1;
            fin_nf = 1'b1;
            st_n   = ST_IDLE;
          end
        end else begin
          req_addr_o = rd_ptr;
          ret_n      = ST_NXTKEY;
          st_n       = ST_RWAIT;
        end
      end
      ST_NXTKEY: begin
        if (op_q == CMD_INSERT && rd_gt) begin
          req_we_o    = 1'b1;
          req_addr_o  = link_of(newp_q);
          req_wdata_o = DATA_W'(nxt_q);
          st_n        = ST_WFIRST;
        end else if (op_q == CMD_DELETE && rd_eq) begin
          req_addr_o = link_of(nxt_q);
          ret_n      = ST_NXTLINK;
          st_n       = ST_RWAIT;
        end else begin
          cur_n      = nxt_q;
          req_addr_o = link_of(nxt_q);
          ret_n      = ST_CURLINK;
          st_n       = ST_RWAIT;
        end
      end
      ST_NXTLINK: begin
        req_we_o    = 1'b1;
        req_addr_o  = link_of(cur_q);
        req_wdata_o = mem_rdata_i;
        st_n        = ST_WLAST;
      end
      ST_WFIRST: begin
        req_we_o    = 1'b1;
        req_addr_o  = link_of(cur_q);
        req_wdata_o = DATA_W'(newp_q);
        st_n        = ST_WLAST;
      end
      ST_WLAST: begin
        fin  = 1'b1;
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q       <= ST_IDLE;
      ret_q      <= ST_IDLE;
      op_q       <= CMD_INSERT;
      head_q     <= '0;
      cur_q      <= '0;
      nxt_q      <= '0;
      newp_q     <= '0;
      key_q      <= '0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      notfound_o <= 1'b0;
    end else begin
      st_q   <= st_n;
      ret_q  <= ret_n;
      op_q   <= op_n;
      head_q <= head_n;
      cur_q  <= cur_n;
      nxt_q  <= nxt_n;
      newp_q <= newp_n;
      key_q  <= key_n;
      busy_o <= (st_n != ST_IDLE);
      done_o <= fin;
      if (fin)         notfound_o <= fin_nf;
      else if (accept) notfound_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sll_list_mgr.sv
module sll_list_mgr #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              cmd_i,
  input  logic [DATA_W-1:0] arg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              notfound_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;

  sll_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start_i),
    .cmd_i       (cmd_i),
    .arg_i       (arg_i),
    .mem_rdata_i (mem_rdata_i),
    .req_we_o    (req_we),
    .req_addr_o  (req_addr),
    .req_wdata_o (req_wdata),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .notfound_o  (notfound_o)
  );

  sll_mem_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .we_n_i      (req_we),
    .addr_n_i    (req_addr),
    .wdata_n_i   (req_wdata),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );
endmodule

// File: rtl/sll_list_mgr_chk.sv
module sll_list_mgr_chk (
  input logic clk_i,
  input logic rst_i,
  input logic busy_i,
  input logic done_i,
  input logic nf_i,
  input logic we_i
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    rst_i |=> (!busy_i && !done_i && !nf_i && !we_i));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_i |=> !done_i);

  // R9
  busy_end_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy_i) |-> done_i);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_i |-> !busy_i);

  // R8
  nf_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(nf_i) |-> done_i);

  // R8
  nf_low_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_i |-> !nf_i);

  // R10
  we_in_cmd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    we_i |-> busy_i);
endmodule

bind sll_list_mgr sll_list_mgr_chk u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .busy_i (busy_o),
  .done_i (done_o),
  .nf_i   (notfound_o),
  .we_i   (mem_we_o)
);

// File: tb/sll_list_mgr_tb_top.sv
module sll_list_mgr_tb_top;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int WORDS  = 256;
  localparam int SLOTS  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              cmd = 1'b0;
  logic [DATA_W-1:0] arg = '0;
  logic              busy, done, notfound, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  logic [31:0] mem [WORDS];
  logic        bwe = 1'b0;
  logic [7:0]  bidx = '0;
  logic [31:0] bdat = '0;

  int checks = 0;
  int errors = 0;

  int unsigned m_addr [SLOTS];
  int unsigned m_key  [SLOTS];
  int          m_cnt = 0;
  int unsigned s_key  [SLOTS];
  bit          s_used [SLOTS];

  always #5 clk = ~clk;

  sll_list_mgr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_i(rst), .start_i(start), .cmd_i(cmd), .arg_i(arg),
    .busy_o(busy), .done_o(done), .notfound_o(notfound),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (bwe) mem[bidx] <= bdat;
    else if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:2]];
  end

  function automatic int unsigned slot_addr(input int s);
    return 32 * (s + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic bwr(input int word, input logic [31:0] v);
    @(negedge clk); bwe = 1'b1; bidx = word[7:0]; bdat = v;
    @(negedge clk); bwe = 1'b0;
  endtask

  task automatic put_rec(input int s, input int unsigned key);
    int w = slot_addr(s) / 4;
    bwr(w, key);
    bwr(w + 1, 32'hBAD0_0000 | s);
    for (int j = 0; j < 3; j++) bwr(w + 2 + j, 32'hA000_0000 + s * 16 + j);
    s_key[s] = key; s_used[s] = 1'b1;
  endtask

  task automatic run_cmd(input logic c, input logic [31:0] a, output bit nf);
    @(negedge clk); start = 1'b1; cmd = c; arg = a;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R9", "busy at done", busy, 0);
    nf = notfound;
    @(negedge clk);
    chk(done == 1'b0, "R9", "done pulse width", done, 0);
  endtask

  task automatic check_list(input string tag);
    for (int i = 0; i < m_cnt; i++) begin
      int unsigned exp = (i == m_cnt - 1) ? 0 : m_addr[i + 1];
      chk(mem[(m_addr[i] + 4) / 4] == exp, tag, "link word",
          mem[(m_addr[i] + 4) / 4], exp);
    end
    for (int s = 0; s < SLOTS; s++) begin
      if (s_used[s]) begin
        int w = slot_addr(s) / 4;
        chk(mem[w] == s_key[s], "R10", "key word", mem[w], s_key[s]);
        for (int j = 0; j < 3; j++)
          chk(mem[w + 2 + j] == 32'hA000_0000 + s * 16 + j, "R10",
              "payload word", mem[w + 2 + j], 32'hA000_0000 + s * 16 + j);
      end
    end
  endtask

  task automatic do_insert(input int s);
    int    pos = m_cnt;
    string tg;
    bit    nf;
    for (int i = m_cnt - 1; i >= 0; i--) if (m_key[i] > s_key[s]) pos = i;
    if (m_cnt == 0)        tg = "R2";
    else if (pos == 0)     tg = "R3";
    else if (pos == m_cnt) tg = "R5";
    else                   tg = "R4";
    for (int i = m_cnt; i > pos; i--) begin
      m_addr[i] = m_addr[i - 1]; m_key[i] = m_key[i - 1];
    end
    m_addr[pos] = slot_addr(s); m_key[pos] = s_key[s]; m_cnt++;
    run_cmd(1'b0, slot_addr(s), nf);
    chk(nf == 1'b0, tg, "notfound after insert", nf, 0);
    check_list(tg);
  endtask

  task automatic do_delete(input int unsigned id);
    int    idx = -1;
    string tg;
    bit    nf;
    for (int i = m_cnt - 1; i >= 0; i--) if (m_key[i] == id) idx = i;
    if (idx < 0)       tg = "R8";
    else if (idx == 0) tg = "R6";
    else               tg = "R7";
    if (idx >= 0) begin
      for (int i = idx; i < m_cnt - 1; i++) begin
        m_addr[i] = m_addr[i + 1]; m_key[i] = m_key[i + 1];
      end
      m_cnt--;
    end
    run_cmd(1'b1, id, nf);
    chk(nf == (idx < 0), tg, "notfound after delete", nf, idx < 0);
    check_list(tg);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned kv [4];
    kv[0] = 10; kv[1] = 20; kv[2] = 30; kv[3] = 40;
    for (int s = 0; s < SLOTS; s++) s_used[s] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet outputs and empty list after reset
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(notfound == 1'b0, "R1", "notfound after reset", notfound, 0);
    chk(mem_we == 1'b0, "R1", "write enable after reset", mem_we, 0);
    do_delete(5);

    // R3: unsigned comparison, top-bit key sorts above small key
    put_rec(0, 32'h8000_0000);
    put_rec(1, 1);
    do_insert(0);
    do_insert(1);
    do_delete(1);
    do_delete(32'h8000_0000);

    // every arrival order of four distinct keys
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              int p [4];
              p[0] = a; p[1] = b; p[2] = c; p[3] = d;
              for (int j = 0; j < 4; j++) put_rec(j, kv[p[j]]);
              for (int j = 0; j < 4; j++) do_insert(j);
              do_delete(25);
              for (int j = 0; j < 4; j++) do_delete(kv[p[(j + 2) % 4]]);
              do_delete(10);
            end
          end

    // R4: equal keys keep insertion order
    put_rec(4, 50); put_rec(5, 50); put_rec(6, 40); put_rec(7, 50);
    do_insert(4); do_insert(5); do_insert(6); do_insert(7);
    do_delete(50); do_delete(50); do_delete(40); do_delete(50);

    // R9: a start pulse during a running insert is ignored
    put_rec(1, 20);
    do_insert(1);
    put_rec(0, 30);
    begin
      bit nf;
      int extra = 0;
      m_addr[1] = slot_addr(0); m_key[1] = 30; m_cnt = 2;
      @(negedge clk); start = 1'b1; cmd = 1'b0; arg = slot_addr(0);
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R9", "busy after start", busy, 1);
      @(negedge clk); start = 1'b1; cmd = 1'b1; arg = 20;
      @(negedge clk); start = 1'b0;
      while (!done) @(negedge clk);
      nf = notfound;
      chk(nf == 1'b0, "R9", "notfound of running insert", nf, 0);
      repeat (6) begin
        @(negedge clk);
        if (done || busy) extra++;
      end
      chk(extra == 0, "R9", "activity after ignored start", extra, 0);
      check_list("R9");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule